// File: doc/BRIEF.md
# Display-Function PCI Configuration Register File

This block holds the 256-byte configuration space of a single-function PCI display controller. A host-side access port presents a byte address, an access length of one to four bytes, read and write strobes and 32-bit data buses. Behind that port every byte follows its own write rule. Identification bytes come from a power-up image. The command and status pair has reset values. The low byte of the command register and the low byte of the status register refuse writes. The first base address register keeps its type nibble. A window of header offsets discards any write that starts inside it.

Two restore inputs are provided. The asynchronous active-low reset reloads only the command and status bytes and clears the output registers. The synchronous `init` input rebuilds the whole space from the power-up image. The current 32-bit base address is always available at a port for downstream address decode. A one-cycle pulse marks every write that actually changed it.

Top module: `cfgspace_regfile`

## Requirements
- R1: A cycle with `init` high loads the power-up image. The vendor word at 0x00 is 0x1234 and the device word at 0x02 is 0x1111, both stored low byte first. Byte 0x0B is 0x03. The 32-bit word at 0x10 is 0x00000008. Every other byte reads 0x00, including the command and status bytes and bytes 0x0A and 0x0E. `init` takes priority over a write in the same cycle.
- R2: Asserting `rst_n` low sets bytes 0x04..0x07 to 0x03, 0x00, 0x00, 0x02, so the 32-bit read at 0x04 returns 0x02000003. It leaves every other byte unchanged, and `acc_rdata` and `bar_update` read zero.
- R3: A write never changes byte 0x04 or byte 0x06. The other bytes of the same access are still written.
- R4: A write to byte 0x10 replaces only bits [7:4] of that byte and keeps bits [3:0]. Bytes 0x11..0x13 take the written data in full.
- R5: A write whose start address lies in 0x14..0x33 inclusive changes no byte. A write that starts below 0x14 and runs into 0x14 stores all of its bytes.
- R6: A length of 0 or of 5..7 makes a read return 0xFFFFFFFF and makes a write change nothing.
- R7: A write of length L stores data bits [8k+7:8k] at address start+k for k from 0 to L-1. Addresses wrap modulo 256.
- R8: A read of length L returns byte start+k in lane k (bits [8k+7:8k]) for k < L, with addresses wrapping modulo 256. The lanes above L read zero. `acc_rdata` is registered: it is updated on the clock edge that samples `acc_rd`, holds until the next read, and shows the contents from before any write in the same cycle.
- R9: `bar_update` is high for exactly the one cycle after a write edge in which at least one of bytes 0x10..0x13 changed value. It stays low when the written values equal the stored ones, and it stays low on `init`.
- R10: `bar_addr` always equals bytes 0x13..0x10 as one little-endian word. It changes only through a write or `init`.
- R11: Every byte not covered by R3..R5 behaves as plain read/write storage, the identification bytes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| init | input | 1 | Synchronous reload of the power-up image |
| acc_addr | input | 8 | Start byte address of the access |
| acc_len | input | 3 | Access length in bytes, 1..4 valid |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 32 | Write data, least significant byte goes to the start address |
| acc_rdata | output | 32 | Registered read data |
| bar_addr | output | 32 | Current content of the base address register |
| bar_update | output | 1 | One-cycle pulse after a write that changed the base address |

## Verification
A byte cell that takes the wrong rule or the wrong enable corrupts storage without any visible effect until that byte is read back. For that reason every rule is followed by a read in the very next cycle, and `acc_rdata` shows the fault one cycle after the read strobe. The base address bytes are different: a wrong value there shows on `bar_addr` in the cycle right after the faulty edge, and a wrong change test shows on `bar_update` in that same cycle. Because the reference model is compared on every clock, a fault in the lane mapping or the address wrap shows on the first read that crosses the affected boundary.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

  // Offsets whose behaviour is decoded by the byte cells
  localparam logic [7:0] OFS_CMD_LO  = 8'h04;
  localparam logic [7:0] OFS_STS_LO  = 8'h06;
  localparam logic [7:0] OFS_BAR     = 8'h10;
  localparam logic [7:0] OFS_HOLE_LO = 8'h14;
  localparam logic [7:0] OFS_HOLE_HI = 8'h33;

  typedef enum logic [1:0] {
    RULE_RW,
    RULE_LOCK,
    RULE_KEEP_LOW
  } byte_rule_e;

  function automatic byte_rule_e rule_of(int unsigned idx);
    if (idx == int'(OFS_CMD_LO) || idx == int'(OFS_STS_LO)) return RULE_LOCK;
    if (idx == int'(OFS_BAR)) return RULE_KEEP_LOW;
    return RULE_RW;
  endfunction

  // Power-up image loaded by init
  function automatic logic [7:0] init_image(int unsigned idx);
    case (idx)
      0:       return 8'h34;
      1:       return 8'h12;
      2:       return 8'h11;
      3:       return 8'h11;
      11:      return 8'h03;
      16:      return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  // Bytes restored by the asynchronous reset
  function automatic bit has_reset(int unsigned idx);
    return (idx >= 4) && (idx <= 7);
  endfunction

  function automatic logic [7:0] reset_image(int unsigned idx);
    case (idx)
      4:       return 8'h03;
      7:       return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_byte_cell.sv
module cfg_byte_cell
  import cfgspace_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_i,
  input  logic       we_i,
  input  logic [7:0] wd_i,
  output logic [7:0] q_o,
  output logic [7:0] nxt_o
);

  localparam byte_rule_e RULE = rule_of(IDX);
  localparam logic [7:0] INIT_V = init_image(IDX);
  localparam logic [7:0] RST_V  = reset_image(IDX);

  logic       en;
  logic [7:0] d;

  // Value a write would leave in this byte
  always_comb begin
    case (RULE)
      RULE_LOCK:     nxt_o = q_o;
      RULE_KEEP_LOW: nxt_o = {wd_i[7:4], q_o[3:0]};
      default:       nxt_o = wd_i;
    endcase
  end

  assign en = init_i | we_i;
  assign d  = init_i ? INIT_V : nxt_o;

  generate
    if (has_reset(IDX)) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_o <= RST_V;
        else if (en) q_o <= d;
      end
    end else begin : g_nrst
      always_ff @(posedge clk) begin
        if (en) q_o <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
  import cfgspace_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LEN_W  = 3
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [LEN_W-1:0]                len_i,
  input  logic                            wr_i,
  input  logic [8*LANES-1:0]              wdata_i,
  output logic [(1<<ADDR_W)-1:0]          we_o,
  output logic [(1<<ADDR_W)-1:0][7:0]     wd_o
);

  localparam int unsigned NB   = 1 << ADDR_W;
  localparam int unsigned LSEL = $clog2(LANES);

  logic len_ok;
  logic in_hole;
  logic wr_go;

  assign len_ok  = (len_i != '0) && (len_i <= LEN_W'(LANES));
  assign in_hole = (addr_i >= ADDR_W'(OFS_HOLE_LO)) && (addr_i <= ADDR_W'(OFS_HOLE_HI));
  assign wr_go   = wr_i & len_ok & ~in_hole;

  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic [ADDR_W-1:0] off;
    assign off     = ADDR_W'(j) - addr_i;
    assign we_o[j] = wr_go && (off < ADDR_W'(len_i));
    assign wd_o[j] = wdata_i[{off[LSEL-1:0], 3'b000} +: 8];
  end

endmodule

// File: rtl/cfg_rd_assemble.sv
module cfg_rd_assemble #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LEN_W  = 3
) (
  input  logic [(1<<ADDR_W)-1:0][7:0] bytes_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [LEN_W-1:0]            len_i,
  output logic [8*LANES-1:0]          word_o
);

  logic               len_ok;
  logic [8*LANES-1:0] lanes;

  assign len_ok = (len_i != '0) && (len_i <= LEN_W'(LANES));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W-1:0] a;
    assign a = addr_i + ADDR_W'(k);
    assign lanes[8*k +: 8] = (LEN_W'(k) < len_i) ? bytes_i[a] : 8'h00;
  end

  assign word_o = len_ok ? lanes : '1;

endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
  import cfgspace_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned LEN_W = $clog2(LANES + 1),
  localparam int unsigned DW    = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     acc_rdata,
  output logic [31:0]       bar_addr,
  output logic              bar_update
);

  localparam int unsigned NB     = 1 << ADDR_W;
  localparam int unsigned BAR_LO = int'(OFS_BAR);

  logic [NB-1:0]      we;
  logic [NB-1:0][7:0] wd;
  logic [NB-1:0][7:0] q;
  logic [NB-1:0][7:0] nxt;
  logic [DW-1:0]      rd_word;
  logic [3:0]         bar_diff;

  logic [DW-1:0] rd_q, rd_d;
  logic          upd_q, upd_d;

  cfg_wr_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .LEN_W(LEN_W)) u_dec (
    .addr_i (acc_addr),
    .len_i  (acc_len),
    .wr_i   (acc_wr),
    .wdata_i(acc_wdata),
    .we_o   (we),
    .wd_o   (wd)
  );

  for (genvar j = 0; j < NB; j++) begin : g_cell
    cfg_byte_cell #(.IDX(j)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .init_i(init),
      .we_i  (we[j]),
      .wd_i  (wd[j]),
      .q_o   (q[j]),
      .nxt_o (nxt[j])
    );
  end

  cfg_rd_assemble #(.ADDR_W(ADDR_W), .LANES(LANES), .LEN_W(LEN_W)) u_rd (
    .bytes_i(q),
    .addr_i (acc_addr),
    .len_i  (acc_len),
    .word_o (rd_word)
  );

  for (genvar k = 0; k < 4; k++) begin : g_bar
    assign bar_diff[k]        = we[BAR_LO+k] && (nxt[BAR_LO+k] != q[BAR_LO+k]);
    assign bar_addr[8*k +: 8] = q[BAR_LO+k];
  end

  // Next-state logic
  always_comb begin
    rd_d  = acc_rd ? rd_word : rd_q;
    upd_d = (|bar_diff) & ~init;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      upd_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      upd_q <= upd_d;
    end
  end

  assign acc_rdata  = rd_q;
  assign bar_update = upd_q;

endmodule

// File: rtl/cfgspace_regfile_chk.sv
module cfgspace_regfile_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned LEN_W = $clog2(LANES + 1),
  localparam int unsigned DW    = 8 * LANES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [LEN_W-1:0]  acc_len,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [DW-1:0]     acc_rdata,
  input logic [31:0]       bar_addr,
  input logic              bar_update
);

  logic bad_len;
  logic hole;
  assign bad_len = (acc_len == '0) || (acc_len > LEN_W'(LANES));
  assign hole    = (acc_addr >= ADDR_W'(8'h14)) && (acc_addr <= ADDR_W'(8'h33));

  // R9
  upd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_update |-> ($past(acc_wr) && !$past(init)));

  // R9
  upd_real_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_update |-> (bar_addr != $past(bar_addr)));

  // R10
  bar_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_wr && !init) |=> $stable(bar_addr));

  // R6
  bad_len_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && bad_len) |=> (acc_rdata == '1));

  // R5
  hole_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !init && hole) |=> !bar_update);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(acc_rdata));

  // R8
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_len == LEN_W'(1)) |=> (acc_rdata[DW-1:8] == '0));

endmodule

bind cfgspace_regfile cfgspace_regfile_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .init      (init),
  .acc_addr  (acc_addr),
  .acc_len   (acc_len),
  .acc_rd    (acc_rd),
  .acc_wr    (acc_wr),
  .acc_rdata (acc_rdata),
  .bar_addr  (bar_addr),
  .bar_update(bar_update)
);

// File: tb/cfgspace_regfile_bench.sv
`timescale 1ns/1ps
module cfgspace_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [2:0]  acc_len = '0;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [31:0] bar_addr;
  logic        bar_update;

  always #2.5 clk = ~clk;

  cfgspace_regfile u_cfgspace_regfile (
    .clk(clk), .rst_n(rst_n), .init(init),
    .acc_addr(acc_addr), .acc_len(acc_len), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .bar_addr(bar_addr), .bar_update(bar_update)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R2";
  bit    ready = 0;
  bit    finished = 0;

  // Behavioural reference model
  logic [7:0]  m [256];
  logic [31:0] exp_rd = '0;
  logic        exp_upd = 1'b0;

  function automatic logic [31:0] model_read(logic [7:0] a, logic [2:0] l);
    logic [31:0] w = '0;
    if (l == 0 || l > 4) return 32'hFFFF_FFFF;
    for (int k = 0; k < int'(l); k++) w[8*k +: 8] = m[8'(a + 8'(k))];
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m[4] = 8'h03; m[5] = 8'h00; m[6] = 8'h00; m[7] = 8'h02;
      exp_rd = '0;
      exp_upd = 1'b0;
    end else begin
      logic chg;
      chg = 1'b0;
      if (acc_rd) exp_rd = model_read(acc_addr, acc_len);
      if (init) begin
        for (int i = 0; i < 256; i++) m[i] = 8'h00;
        m[0] = 8'h34; m[1] = 8'h12; m[2] = 8'h11; m[3] = 8'h11;
        m[11] = 8'h03; m[16] = 8'h08;
        ready = 1;
      end else if (acc_wr && acc_len >= 1 && acc_len <= 4 &&
                   !(acc_addr >= 8'h14 && acc_addr <= 8'h33)) begin
        for (int i = 0; i < int'(acc_len); i++) begin
          logic [7:0] a, v;
          a = 8'(acc_addr + 8'(i));
          v = acc_wdata[8*i +: 8];
          if (a == 8'h04 || a == 8'h06) v = m[a];
          if (a == 8'h10) v = {v[7:4], m[a][3:0]};
          if (a >= 8'h10 && a <= 8'h13 && v != m[a]) chg = 1'b1;
          m[a] = v;
        end
      end
      exp_upd = chg;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Comparison on every clock
  always @(negedge clk) begin
    if (!finished) begin
      chk(cur_tag, "acc_rdata vs model", acc_rdata, exp_rd);
      chk(cur_tag, "bar_update vs model", {31'b0, bar_update}, {31'b0, exp_upd});
      if (ready) chk(cur_tag, "bar_addr vs model", bar_addr, {m[19], m[18], m[17], m[16]});
    end
  end

  task automatic wr(logic [7:0] a, logic [2:0] l, logic [31:0] d);
    @(negedge clk);
    acc_addr = a; acc_len = l; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [2:0] l);
    @(negedge clk);
    acc_addr = a; acc_len = l; acc_rd = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  task automatic rd_exp(string tag, logic [7:0] a, logic [2:0] l, logic [31:0] e);
    cur_tag = tag;
    rd(a, l);
    chk(tag, "read word", acc_rdata, e);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, got hang expected completion");
    summary();
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R2", "rdata in reset", acc_rdata, 32'h0);
    chk("R2", "bar_update in reset", {31'b0, bar_update}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;

    rd_exp("R1", 8'h00, 3'd4, 32'h1111_1234);
    rd_exp("R1", 8'h08, 3'd4, 32'h0300_0000);
    rd_exp("R1", 8'h0C, 3'd4, 32'h0000_0000);
    rd_exp("R1", 8'h10, 3'd4, 32'h0000_0008);
    chk("R10", "bar_addr after init", bar_addr, 32'h0000_0008);
    rd_exp("R1", 8'h04, 3'd4, 32'h0000_0000);

    cur_tag = "R2";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_exp("R2", 8'h04, 3'd4, 32'h0200_0003);
    rd_exp("R2", 8'h00, 3'd4, 32'h1111_1234);

    cur_tag = "R3";
    wr(8'h04, 3'd4, 32'hAABB_CCDD);
    rd_exp("R3", 8'h04, 3'd4, 32'hAA00_CC03);

    cur_tag = "R4";
    wr(8'h10, 3'd1, 32'h0000_00F5);
    chk("R4", "bar low nibble kept", bar_addr, 32'h0000_00F8);
    chk("R9", "pulse on change", {31'b0, bar_update}, 32'h1);
    @(negedge clk);
    chk("R9", "pulse one cycle", {31'b0, bar_update}, 32'h0);
    cur_tag = "R9";
    wr(8'h10, 3'd1, 32'h0000_00F5);
    chk("R9", "no pulse on same value", {31'b0, bar_update}, 32'h0);
    cur_tag = "R4";
    wr(8'h10, 3'd4, 32'h1234_5677);
    chk("R4", "bar full write", bar_addr, 32'h1234_5678);

    cur_tag = "R5";
    wr(8'h14, 3'd4, 32'hDEAD_BEEF);
    rd_exp("R5", 8'h14, 3'd4, 32'h0);
    wr(8'h33, 3'd2, 32'h0000_BEEF);
    rd_exp("R5", 8'h32, 3'd4, 32'h0);
    wr(8'h13, 3'd2, 32'h0000_A5C3);
    chk("R5", "write from 0x13 spans hole", bar_addr, 32'hC334_5678);
    rd_exp("R5", 8'h14, 3'd1, 32'h0000_00A5);
    cur_tag = "R11";
    wr(8'h34, 3'd2, 32'h0000_5A6B);
    rd_exp("R11", 8'h34, 3'd2, 32'h0000_5A6B);

    rd_exp("R6", 8'h00, 3'd0, 32'hFFFF_FFFF);
    rd_exp("R6", 8'h00, 3'd5, 32'hFFFF_FFFF);
    rd_exp("R6", 8'h10, 3'd7, 32'hFFFF_FFFF);
    cur_tag = "R6";
    wr(8'h40, 3'd0, 32'h1122_3344);
    wr(8'h40, 3'd5, 32'h1122_3344);
    wr(8'h10, 3'd6, 32'hFFFF_FFFF);
    chk("R6", "bar after bad length", bar_addr, 32'hC334_5678);
    rd_exp("R6", 8'h40, 3'd4, 32'h0);

    cur_tag = "R7";
    wr(8'hFE, 3'd4, 32'h4433_2211);
    rd_exp("R7", 8'hFE, 3'd2, 32'h0000_2211);
    rd_exp("R7", 8'h00, 3'd2, 32'h0000_4433);
    rd_exp("R8", 8'h00, 3'd3, 32'h0011_4433);
    rd_exp("R8", 8'hFF, 3'd4, 32'h1144_3322);

    cur_tag = "R11";
    lf = 16'hACE1;
    for (int it = 0; it < 60; it++) begin
      logic [7:0] a;
      logic [2:0] l;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = 8'h40 + {1'b0, lf[6:0]};
      l = 3'(1 + lf[9:8]);
      wr(a, l, {lf, lf ^ 16'h5A5A});
      rd(a, 3'd4);
    end

    cur_tag = "R1";
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    chk("R9", "no pulse on init", {31'b0, bar_update}, 32'h0);
    rd_exp("R1", 8'h10, 3'd4, 32'h0000_0008);
    rd_exp("R1", 8'h04, 3'd4, 32'h0000_0000);
    rd_exp("R1", 8'h40, 3'd4, 32'h0000_0000);
    repeat (2) @(negedge clk);
    summary();
  end

endmodule